// File: doc/BRIEF.md
# Three-Address I2C Write Target

This block is the bus-facing part of an I2C target that only takes writes. It samples the raw SCL and SDA lines on the system clock and cleans them up. It finds START and STOP conditions, shifts in an address byte and acknowledges when the byte matches any one of three 7-bit addresses. After a match it takes a register index byte and then one or more data bytes. Each data byte comes out as a one-cycle write strobe that carries the index and the data, so an internal register file can pick it up. The index steps up by one after every data byte.

Two of the three addresses are held in registers. A write over the same bus to a fixed register index moves them. The third address is fixed. START qualification is strict. When another target pulls SDA low to acknowledge, just after SCL has fallen, the block never reads that edge as a START. Traffic for other devices therefore passes with SDA untouched.

Top module: `i2ct_target`

## Requirements
- R1: While rst_n is low and after its release, sda_oe and wr_stb are both 0.
- R2: A START is taken only when SDA falls while SCL has been high for at least three sampling clocks. An SDA fall that occurs in the same cycle as an SCL fall, or after it, starts nothing and produces no acknowledge.
- R3: An address byte whose upper seven bits equal 0x38, 0x3D or 0x3F (8-bit values 0x70, 0x7A, 0x7E) and whose bit 0 is 0 (write) is acknowledged. The same addresses with bit 0 set to 1 (read) are not acknowledged.
- R4: After an address byte that is not acknowledged, the block drives no acknowledge and issues no strobe until the next START or STOP, whatever bytes follow.
- R5: In an acknowledged write, the index byte and every data byte are acknowledged. Each data byte gives exactly one wr_stb pulse with wr_idx equal to the current index and wr_data equal to the byte.
- R6: The index rises by one after each data byte in a transaction and wraps from 0xFF to 0x00.
- R7: A data write of value V to index 0xCF replaces the address that defaults to 0x70 with V (bits 7:1 compared). The old value is then no longer acknowledged.
- R8: A data write of value V to index 0x43 replaces the address that defaults to 0x7E in the same way. The address 0x7A never changes.
- R9: The acknowledge (sda_oe high) starts after the SCL fall that ends the eighth bit. It is present while SCL is high in the ninth bit and is removed after the SCL fall that ends the ninth bit.
- R10: A STOP at any point returns the block to idle. A partly received data byte gives no strobe.
- R11: A START in the middle of a transaction, including one that follows an unmatched address, restarts address reception.
- R12: While another target owns the bus, sda_oe stays 0 in every bit slot. This holds for every data byte value, after index bytes with bit 0 both set and clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and logic clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| wr_stb | output | 1 | One-cycle write strobe to the register file |
| wr_idx | output | 8 | Register index of the current write |
| wr_data | output | 8 | Data byte of the current write |

## Verification
A table of address bytes is run first. It holds the three write addresses, their read forms and near-miss values, including the bare 7-bit value and the future reprogrammed value. This separates matching on bits 7:1 from matching on all eight bits, and shows that read direction is refused. Foreign multi-byte writes then sweep all 256 data values after an index with bit 0 set and after one with bit 0 clear. Each foreign byte is acknowledged by a modelled target that pulls SDA one clock after SCL falls. That is exactly the edge a loose START detector would misread, so any stray drive exposes it. Directed runs cover index wrap, both reprogrammable slots, a STOP mid-byte, a repeated START after a mismatch, and SDA falls aligned with or just after SCL falls from idle.

// File: rtl/i2ct_pkg.sv
// Shared types for the three-address I2C write target.
// Assumes: byte-wide index and data, 7-bit addressing only.
package i2ct_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INDEX,
        ST_DATA,
        ST_ACK,
        ST_SKIP
    } i2ct_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/i2ct_line_filter.sv
// Synchronizes one asynchronous bus line and removes single-sample glitches
// with a majority vote over the last VOTE_TAPS synchronized samples.
// Assumes: line idles at RESET_VAL; VOTE_TAPS is odd; latency is
// SYNC_STAGES + VOTE_TAPS - 1 clocks for a clean transition with 3 taps.
module i2ct_line_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   VOTE_TAPS   = 3,
    parameter logic RESET_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(VOTE_TAPS + 1);
    localparam logic [CW-1:0] HALF = CW'(VOTE_TAPS / 2);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   taps_q;
    logic [CW-1:0]          ones;

    // Synchronizer chain followed by the vote history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{RESET_VAL}};
            taps_q <= {VOTE_TAPS{RESET_VAL}};
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            taps_q <= {taps_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    // Count ones in the history.
    always_comb begin
        ones = '0;
        for (int i = 0; i < VOTE_TAPS; i++) begin
            ones = ones + {{(CW-1){1'b0}}, taps_q[i]};
        end
    end

    // Register the majority decision.
    always_ff @(posedge clk) begin
        if (!rst_n) line_o <= RESET_VAL;
        else        line_o <= (ones > HALF);
    end
endmodule

// File: rtl/i2ct_bus_events.sv
// Turns filtered SCL/SDA into single-cycle START, STOP and SCL edge pulses.
// Assumes: inputs are already synchronized. A START needs SCL high for
// MIN_HIGH clocks before the current one, so an SDA fall that is not
// strictly inside an SCL high phase is never taken as a START.
module i2ct_bus_events #(
    parameter int MIN_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    localparam int CNT_W = $clog2(MIN_HIGH + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_HIGH);

    logic             scl_q;
    logic             sda_q;
    logic [CNT_W-1:0] high_cnt;

    // Previous-sample registers and a saturating SCL-high counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            high_cnt <= '0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (!scl_f)                high_cnt <= '0;
            else if (high_cnt != CNT_SAT) high_cnt <= high_cnt + 1'b1;
        end
    end

    // Edge and condition decoding.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f & (high_cnt == CNT_SAT);
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2ct_addr_slots.sv
// Holds the target's address slots and compares an incoming address.
// Slots flagged in SLOT_PROG reload from a register write to their own
// index; the rest are constants. Only bits 7:1 take part.
module i2ct_addr_slots #(
    parameter int                       NUM_SLOTS     = 3,
    parameter logic [NUM_SLOTS*8-1:0]   SLOT_DEFAULTS = {8'h7E, 8'h7A, 8'h70},
    parameter logic [NUM_SLOTS*8-1:0]   SLOT_CFG_IDX  = {8'h43, 8'h00, 8'hCF},
    parameter logic [NUM_SLOTS-1:0]     SLOT_PROG     = 3'b101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_idx,
    input  logic [6:0] cfg_addr7,
    input  logic [6:0] addr7,
    output logic       hit
);
    logic [NUM_SLOTS-1:0] hits;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [6:0] slot_q;
        if (SLOT_PROG[g]) begin : g_prog
            // Reloadable slot: takes bits 7:1 of a write to its index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q <= SLOT_DEFAULTS[g*8+1 +: 7];
                else if (cfg_we && (cfg_idx == SLOT_CFG_IDX[g*8 +: 8]))
                    slot_q <= cfg_addr7;
            end
        end else begin : g_fixed
            assign slot_q = SLOT_DEFAULTS[g*8+1 +: 7];
        end
        assign hits[g] = (slot_q == addr7);
    end

    assign hit = |hits;
endmodule

// File: rtl/i2ct_target.sv
// Write-only I2C target with three matched addresses.
// Receives address, index and data bytes, acknowledges its own transfers,
// and presents each data byte as a one-cycle strobe. Assumes clk runs many
// times faster than SCL (at least 12 clocks per SCL half period).
module i2ct_target
    import i2ct_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter int   VOTE_TAPS   = 3,
    parameter int   MIN_HIGH    = 2,
    parameter logic [7:0] ADDR_A_DEF = 8'h70,
    parameter logic [7:0] ADDR_B_FIX = 8'h7A,
    parameter logic [7:0] ADDR_C_DEF = 8'h7E,
    parameter logic [7:0] CFG_IDX_A  = 8'hCF,
    parameter logic [7:0] CFG_IDX_C  = 8'h43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int BIT_CW = $clog2(BYTE_W + 1);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W);

    logic scl_f, sda_f;
    logic start_det, stop_det, scl_rise, scl_fall;
    logic addr_hit;

    i2ct_state_e       state_q, ret_q;
    logic [BIT_CW-1:0] bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] index_q;
    logic              byte_done;

    i2ct_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS), .RESET_VAL(1'b1))
        u_scl_filt (.clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    i2ct_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS), .RESET_VAL(1'b1))
        u_sda_filt (.clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    i2ct_bus_events #(.MIN_HIGH(MIN_HIGH)) u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    i2ct_addr_slots #(
        .NUM_SLOTS(3),
        .SLOT_DEFAULTS({ADDR_C_DEF, ADDR_B_FIX, ADDR_A_DEF}),
        .SLOT_CFG_IDX({CFG_IDX_C, 8'h00, CFG_IDX_A}),
        .SLOT_PROG(3'b101)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(wr_stb), .cfg_idx(wr_idx), .cfg_addr7(wr_data[7:1]),
        .addr7(shreg[7:1]), .hit(addr_hit)
    );

    assign byte_done = scl_fall && (bit_cnt == LAST_BIT);

    // Transaction state machine: byte reception, ACK slots, write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            index_q <= '0;
            wr_stb  <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (stop_det) begin
                state_q <= ST_IDLE;
                bit_cnt <= '0;
            end else if (start_det) begin
                state_q <= ST_ADDR;
                bit_cnt <= '0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_INDEX, ST_DATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit && !shreg[0]) begin
                                    state_q <= ST_ACK;
                                    ret_q   <= ST_INDEX;
                                end else begin
                                    state_q <= ST_SKIP;
                                end
                            end else if (state_q == ST_INDEX) begin
                                index_q <= shreg;
                                state_q <= ST_ACK;
                                ret_q   <= ST_DATA;
                            end else begin
                                wr_stb  <= 1'b1;
                                wr_idx  <= index_q;
                                wr_data <= shreg;
                                index_q <= index_q + 1'b1;
                                state_q <= ST_ACK;
                                ret_q   <= ST_DATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) state_q <= ret_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Open-drain pull while in an acknowledge slot.
    assign sda_oe = (state_q == ST_ACK);
endmodule

// File: rtl/i2ct_target_chk.sv
// Temporal checks on the I2C target, attached through bind.
module i2ct_target_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic wr_stb,
    input logic start_det,
    input logic stop_det,
    input logic scl_fall,
    input logic scl_f
);
    assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_stb_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> sda_oe);

    assert_ack_begins_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    assert_ack_ends_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> ($past(scl_fall) || $past(stop_det) || $past(start_det)));

    assert_start_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |-> (scl_f && $past(scl_f) && $past(scl_f, 2)));

    assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !wr_stb));
endmodule

bind i2ct_target i2ct_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .start_det(start_det), .stop_det(stop_det),
    .scl_fall(scl_fall), .scl_f(scl_f)
);

// File: tb/i2ct_target_tb.sv
module i2ct_target_tb;
    localparam int Q  = 6;        // clocks per quarter bit
    localparam int WD = 195000;   // watchdog limit in clocks
    localparam int NV = 10;
    // {address byte, index, data, acknowledge expected}
    localparam logic [24:0] VEC [NV] = '{
        {8'h70, 8'h10, 8'hA5, 1'b1},
        {8'h71, 8'h10, 8'h5A, 1'b0},
        {8'h7A, 8'h11, 8'h3C, 1'b1},
        {8'h7B, 8'h11, 8'hC3, 1'b0},
        {8'h7E, 8'h12, 8'h0F, 1'b1},
        {8'h7F, 8'h12, 8'hF0, 1'b0},
        {8'h72, 8'h13, 8'h11, 1'b0},
        {8'h38, 8'h14, 8'h22, 1'b0},
        {8'h7C, 8'h15, 8'h33, 1'b0},
        {8'hF0, 8'h16, 8'h44, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, oth_low = 1'b0;
    logic sda_bus;
    logic dut_oe, dut_stb;
    logic [7:0] dut_idx, dut_data;
    bit allow_oe = 1'b0;
    bit done = 1'b0;
    int checks = 0, errors = 0, viol = 0, stb_cnt = 0;
    logic [7:0] cap_i [16];
    logic [7:0] cap_d [16];

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~dut_oe & ~oth_low;

    i2ct_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(dut_oe), .wr_stb(dut_stb), .wr_idx(dut_idx), .wr_data(dut_data)
    );

    // Monitor: strobe capture and stray-drive counter (R12).
    always @(negedge clk) begin
        if (rst_n) begin
            if (dut_stb) begin
                cap_i[stb_cnt % 16] = dut_idx;
                cap_d[stb_cnt % 16] = dut_data;
                stb_cnt = stb_cnt + 1;
            end
            if (dut_oe && !allow_oe) viol = viol + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(3*Q);
    endtask

    // One byte plus ACK slot. oth: a foreign target acknowledges one clock
    // after SCL falls. exp: DUT may drive in this ACK slot.
    task automatic send_byte(input logic [7:0] b, input bit oth, input bit exp,
                             output bit dut_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0;
            if (i == 0) allow_oe = exp;
            if (i == 0 && oth) begin tick(1); oth_low = 1'b1; tick(Q-1); end
            else tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        dut_ack = dut_oe && !sda_bus;
        tick(Q);
        m_scl = 1'b0;
        if (oth) begin tick(1); oth_low = 1'b0; tick(Q-1); end
        else tick(Q);
        tick(2);
        allow_oe = 1'b0;
    endtask

    task automatic wr_txn(input logic [7:0] a, input logic [7:0] i, input logic [7:0] d,
                          input bit exp, output bit k0, output bit k1, output bit k2);
        bus_start();
        send_byte(a, 1'b0, exp, k0);
        send_byte(i, 1'b0, exp, k1);
        send_byte(d, 1'b0, exp, k2);
        bus_stop();
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired (all requirements)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit k0, k1, k2, anyk;
        int base;
        tick(10);
        // R1: reset state
        check(dut_oe == 1'b0 && dut_stb == 1'b0, "R1", "outputs in reset", {dut_oe, dut_stb}, 0);
        rst_n = 1'b1;
        tick(12);
        check(dut_oe == 1'b0 && dut_stb == 1'b0, "R1", "outputs after reset", {dut_oe, dut_stb}, 0);

        // Address table: R3 matches, R4 mismatches, R5 strobes
        for (int v = 0; v < NV; v++) begin
            base = stb_cnt;
            wr_txn(VEC[v][24:17], VEC[v][16:9], VEC[v][8:1], VEC[v][0], k0, k1, k2);
            check(k0 == VEC[v][0], VEC[v][0] ? "R3" : "R4", "address ack", k0, VEC[v][0]);
            check({k1, k2} == {2{VEC[v][0]}}, VEC[v][0] ? "R5" : "R4", "index/data ack",
                  {k1, k2}, {2{VEC[v][0]}});
            check(stb_cnt - base == int'(VEC[v][0]), VEC[v][0] ? "R5" : "R4", "strobe count",
                  stb_cnt - base, VEC[v][0]);
            if (VEC[v][0])
                check({cap_i[base % 16], cap_d[base % 16]} == VEC[v][16:1], "R5", "strobe idx/data",
                      {cap_i[base % 16], cap_d[base % 16]}, VEC[v][16:1]);
        end
        check(dut_oe == 1'b0, "R9", "released after table", dut_oe, 0);

        // R6: auto-increment with wrap
        base = stb_cnt;
        bus_start();
        send_byte(8'h7A, 1'b0, 1'b1, k0);
        send_byte(8'hFE, 1'b0, 1'b1, k1);
        anyk = 1'b1;
        for (int n = 0; n < 3; n++) begin
            send_byte(8'h11 * (n + 1), 1'b0, 1'b1, k2);
            anyk &= k2;
        end
        bus_stop();
        check(anyk && stb_cnt - base == 3, "R6", "burst acks/count", stb_cnt - base, 3);
        check(cap_i[base % 16] == 8'hFE && cap_i[(base+1) % 16] == 8'hFF && cap_i[(base+2) % 16] == 8'h00,
              "R6", "index sequence wrap", cap_i[(base+2) % 16], 0);
        check(cap_d[(base+2) % 16] == 8'h33, "R6", "third data", cap_d[(base+2) % 16], 8'h33);

        // R7: move first address to 0xF0
        wr_txn(8'h7A, 8'hCF, 8'hF0, 1'b1, k0, k1, k2);
        wr_txn(8'h70, 8'h20, 8'h01, 1'b0, k0, k1, k2);
        check(!k0, "R7", "old address refused", k0, 0);
        base = stb_cnt;
        wr_txn(8'hF0, 8'h21, 8'h02, 1'b1, k0, k1, k2);
        check(k0 && k2 && stb_cnt - base == 1 && cap_d[base % 16] == 8'h02, "R7", "new address",
              {k0, k2}, 3);

        // R8: move third address to 0x50, second stays fixed
        wr_txn(8'h7A, 8'h43, 8'h50, 1'b1, k0, k1, k2);
        wr_txn(8'h7E, 8'h22, 8'h03, 1'b0, k0, k1, k2);
        check(!k0, "R8", "old third address refused", k0, 0);
        wr_txn(8'h50, 8'h23, 8'h04, 1'b1, k0, k1, k2);
        check(k0 && k2, "R8", "new third address", {k0, k2}, 3);
        wr_txn(8'h7A, 8'h24, 8'h05, 1'b1, k0, k1, k2);
        check(k0, "R8", "fixed address unchanged", k0, 1);

        // R10: STOP inside a data byte
        base = stb_cnt;
        bus_start();
        send_byte(8'h7A, 1'b0, 1'b1, k0);
        send_byte(8'h30, 1'b0, 1'b1, k1);
        for (int i = 0; i < 4; i++) begin
            m_sda = i[0]; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
        end
        bus_stop();
        check(stb_cnt == base && dut_oe == 1'b0, "R10", "partial byte dropped", stb_cnt - base, 0);
        wr_txn(8'h7A, 8'h31, 8'h77, 1'b1, k0, k1, k2);
        check(stb_cnt - base == 1 && cap_i[base % 16] == 8'h31 && cap_d[base % 16] == 8'h77,
              "R10", "next write clean", cap_d[base % 16], 8'h77);

        // R11: repeated START after a mismatch
        base = stb_cnt;
        bus_start();
        send_byte(8'h98, 1'b0, 1'b0, k0);
        send_byte(8'h7A, 1'b0, 1'b0, k1);
        check(!k0 && !k1, "R4", "skip until START", {k0, k1}, 0);
        bus_start();
        send_byte(8'h7A, 1'b0, 1'b1, k0);
        send_byte(8'h40, 1'b0, 1'b1, k1);
        send_byte(8'h5A, 1'b0, 1'b1, k2);
        bus_stop();
        check(k0 && k2 && stb_cnt - base == 1 && cap_i[base % 16] == 8'h40, "R11",
              "repeated start restarts", stb_cnt - base, 1);

        // R2: SDA falls with or just after SCL fall, then address-like bits
        for (int dly = 0; dly < 3; dly++) begin
            m_scl = 1'b0;
            if (dly > 0) tick(dly);
            m_sda = 1'b0; tick(Q);
            send_byte(8'h7A, 1'b0, 1'b0, k0);
            send_byte(8'h10, 1'b0, 1'b0, k1);
            check(!k0 && !k1, "R2", "no start after SCL fall", dly, 0);
            bus_stop();
        end

        // R12 / R2: foreign writes sweeping all data values
        for (int s = 0; s < 2; s++) begin
            base = stb_cnt;
            anyk = 1'b0;
            bus_start();
            send_byte(8'h98, 1'b1, 1'b0, k0); anyk |= k0;
            send_byte(s == 0 ? 8'h25 : 8'h24, 1'b1, 1'b0, k1); anyk |= k1;
            for (int d = 0; d < 256; d++) begin
                send_byte(d[7:0], 1'b1, 1'b0, k2);
                anyk |= k2;
            end
            bus_stop();
            check(!anyk, "R12", "DUT drove ACK in foreign write", anyk, 0);
            check(stb_cnt == base, "R12", "strobes in foreign write", stb_cnt - base, 0);
        end
        check(viol == 0, "R12", "cycles with stray sda_oe", viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule